// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single operation requests into the bus cycles that a small-page, 8-bit NAND flash expects. A requester asks for one of four operations (page read, page program, block erase, status read) together with a row, a starting column, a half-page pointer and a byte count. The block then walks the flash through the command, address and data cycles of that operation. Every byte travels over one shared 8-bit bus. A command-latch strobe or an address-latch strobe qualifies each byte, and a write pulse or a read pulse moves it.

Page data moves through two byte streams. Program data enters on a valid/ready stream. Read data leaves as one-cycle valid pulses. The block waits on the flash ready line after each page load, program or erase. It refuses program and erase while write protect is active. After every program or erase it reads the flash status byte, and it reports the result with a one-cycle done pulse and two error flags. The device has 16384 page rows of 528 bytes each. Each row is 512 data bytes plus 16 spare bytes. A read starts in either the lower or the upper 256 bytes, chosen by a pointer command.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset and whenever `req_ready` is high, chip select (`flash_sel_n`) is high, both pulse lines are high, and both latch strobes are low.
- R2: Every low pulse on `flash_wr_n` or `flash_rd_n` lasts exactly `PULSE_CYC` cycles. Every high time between pulses lasts at least `PULSE_CYC` cycles. The two pulse lines are never low together.
- R3: A command byte is presented with `flash_cmd_en`=1 and `flash_addr_en`=0. An address byte is presented with `flash_addr_en`=1 and `flash_cmd_en`=0. A data byte is presented with both strobes at 0. All three are latched by the flash on the rising edge of `flash_wr_n`.
- R4: A read (`req_op`=0) sends command 0x00 when `req_half`=0 or 0x01 when `req_half`=1. It then sends three address bytes: the column, row bits 7:0, and row bits 13:8 zero-extended. It waits for ready, then issues `req_len` read pulses. Each captured byte appears on `rd_byte` with a `rd_valid` pulse, in column order.
- R5: A program (`req_op`=1) sends 0x80, the same three address bytes, `req_len` data bytes taken from the write stream in order, and then 0x10. It waits for ready, then sends 0x70 and reads one status byte.
- R6: An erase (`req_op`=2) sends 0x60, row bits 7:0, row bits 13:8, and then 0xD0. It waits for ready, then sends 0x70 and reads one status byte.
- R7: A status read (`req_op`=3) sends 0x70, reads one byte, and presents that byte on `status_byte` during the done pulse.
- R8: If `flash_wprot_n` is 0 when a program or erase is accepted, no bus cycle occurs and chip select stays high. `done` rises in the cycle after acceptance with `err_prot`=1.
- R9: No pulse starts while `flash_ready` is low. After the last address byte of a read, and after the confirm byte of a program or erase, the next bus cycle waits until `flash_ready` has returned high.
- R10: After a program or erase, `err_fail` during the done pulse equals bit 0 of the status byte read back. It is 0 for reads and status reads.
- R11: A request is accepted only while `req_ready` is high, and `req_ready` stays low until the operation ends. `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 status |
| req_row | input | 14 | Page row |
| req_col | input | 8 | Starting column within the selected half |
| req_half | input | 1 | Read pointer: 0 lower, 1 upper 256 bytes |
| req_len | input | 10 | Byte count for read or program |
| wr_byte | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte valid |
| wr_ready | output | 1 | Program data byte taken |
| rd_byte | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data byte valid |
| done | output | 1 | Operation finished (one cycle) |
| err_prot | output | 1 | Refused by write protect |
| err_fail | output | 1 | Status reported failure |
| status_byte | output | 8 | Last status byte read |
| flash_sel_n | output | 1 | Chip select, active low |
| flash_cmd_en | output | 1 | Command-latch strobe |
| flash_addr_en | output | 1 | Address-latch strobe |
| flash_wr_n | output | 1 | Write pulse, active low |
| flash_rd_n | output | 1 | Read pulse, active low |
| flash_bus_out | output | 8 | Bus value driven to flash |
| flash_bus_oe | output | 1 | Bus drive enable |
| flash_bus_in | input | 8 | Bus value from flash |
| flash_wprot_n | input | 1 | Write protect, active low |
| flash_ready | input | 1 | Flash ready (low = busy) |

## Verification
A write-protect refusal must show `done` in the first cycle after acceptance, so the bench samples it at the first falling edge after the accepting rising edge. Every other result has no fixed latency, because it depends on `PULSE_CYC` and on the flash model's busy time. For these the bench gathers each latched byte at the pulse's rising edge and each `rd_valid` byte at a falling edge into queues. It compares those queues against the sequences it expects once `done` arrives. Pulse widths and the quiet-while-busy rule are measured on every falling edge. `done` must be followed one cycle later by `done` low and `req_ready` high.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
   localparam int BUS_W = 8;

   typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_STAT = 2'd3} nseq_op_e;
   typedef enum logic [1:0] {CY_CMD, CY_ADDR, CY_WDAT, CY_RDAT} nseq_cyc_e;
   typedef enum logic [3:0] {ST_IDLE, ST_CMD1, ST_ADDR, ST_WDAT, ST_CMD2, ST_WAIT,
                             ST_SCMD, ST_RDAT, ST_DONE} nseq_st_e;

   localparam logic [BUS_W-1:0] K_PTR_LO = 8'h00;
   localparam logic [BUS_W-1:0] K_PTR_HI = 8'h01;
   localparam logic [BUS_W-1:0] K_PROG   = 8'h80;
   localparam logic [BUS_W-1:0] K_PCONF  = 8'h10;
   localparam logic [BUS_W-1:0] K_ERASE  = 8'h60;
   localparam logic [BUS_W-1:0] K_ECONF  = 8'hD0;
   localparam logic [BUS_W-1:0] K_STAT   = 8'h70;
endpackage

// File: rtl/nseq_strobe.sv
module nseq_strobe
   import nseq_pkg::*;
#(
   parameter int PULSE_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  nseq_cyc_e        kind,
   input  logic [BUS_W-1:0] wbyte,
   input  logic [BUS_W-1:0] bus_in,
   output logic             idle,
   output logic             cyc_done,
   output logic             cmd_en,
   output logic             addr_en,
   output logic             wr_n,
   output logic             rd_n,
   output logic [BUS_W-1:0] bus_out,
   output logic             bus_oe,
   output logic [BUS_W-1:0] rbyte
);
   localparam int CW = $clog2(PULSE_CYC + 1);
   localparam logic [CW-1:0] RELOAD = CW'(PULSE_CYC - 1);

   logic             busy, low_ph;
   logic [CW-1:0]    cnt;
   nseq_cyc_e        kind_q;
   logic [BUS_W-1:0] byte_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         low_ph <= 1'b0;
         cnt    <= '0;
         kind_q <= CY_CMD;
         byte_q <= '0;
         rbyte  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            low_ph <= 1'b1;
            cnt    <= RELOAD;
            kind_q <= kind;
            byte_q <= wbyte;
         end
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end else if (low_ph) begin
         low_ph <= 1'b0;
         cnt    <= RELOAD;
         if (kind_q == CY_RDAT) rbyte <= bus_in;
      end else begin
         busy <= 1'b0;
      end
   end

   assign idle     = !busy;
   assign cyc_done = busy && !low_ph && (cnt == '0);
   assign wr_n     = !(busy && low_ph && kind_q != CY_RDAT);
   assign rd_n     = !(busy && low_ph && kind_q == CY_RDAT);
   assign cmd_en   = busy && kind_q == CY_CMD;
   assign addr_en  = busy && kind_q == CY_ADDR;
   assign bus_oe   = busy && kind_q != CY_RDAT;
   assign bus_out  = bus_oe ? byte_q : '0;
endmodule

// File: rtl/nseq_ctrl.sv
module nseq_ctrl
   import nseq_pkg::*;
#(
   parameter int ROW_W = 14,
   parameter int LEN_W = 10,
   parameter int GUARD = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic [ROW_W-1:0] req_row,
   input  logic [BUS_W-1:0] req_col,
   input  logic             req_half,
   input  logic [LEN_W-1:0] req_len,
   input  logic             wr_valid,
   input  logic [BUS_W-1:0] wr_byte,
   input  logic             wprot_n,
   input  logic             ready,
   input  logic             cyc_idle,
   input  logic             cyc_done,
   input  logic [BUS_W-1:0] rbyte,
   output logic             start,
   output nseq_cyc_e        kind,
   output logic [BUS_W-1:0] wbyte,
   output logic             wr_ready,
   output logic             req_ready,
   output logic             done,
   output logic             err_prot,
   output logic             err_fail,
   output logic [BUS_W-1:0] status_byte,
   output logic             rd_valid,
   output logic             sel_n
);
   localparam int GW = $clog2(GUARD + 1);

   nseq_st_e         st;
   nseq_op_e         op_q;
   logic [ROW_W-1:0] row_q;
   logic [BUS_W-1:0] col_q;
   logic             half_q;
   logic [LEN_W-1:0] len_q, idx;
   logic [GW-1:0]    guard;
   logic [BUS_W-1:0] addr_byte;

   always_comb begin
      case (idx[1:0])
         2'd0:    addr_byte = col_q;
         2'd1:    addr_byte = row_q[7:0];
         default: addr_byte = BUS_W'(row_q >> 8);
      endcase
   end

   always_comb begin
      start = 1'b0;
      kind  = CY_CMD;
      wbyte = '0;
      case (st)
         ST_CMD1: begin
            start = cyc_idle;
            case (op_q)
               OP_READ:  wbyte = half_q ? K_PTR_HI : K_PTR_LO;
               OP_PROG:  wbyte = K_PROG;
               OP_ERASE: wbyte = K_ERASE;
               default:  wbyte = K_STAT;
            endcase
         end
         ST_ADDR: begin start = cyc_idle; kind = CY_ADDR; wbyte = addr_byte; end
         ST_WDAT: begin start = cyc_idle && wr_valid; kind = CY_WDAT; wbyte = wr_byte; end
         ST_CMD2: begin start = cyc_idle; wbyte = (op_q == OP_PROG) ? K_PCONF : K_ECONF; end
         ST_SCMD: begin start = cyc_idle; wbyte = K_STAT; end
         ST_RDAT: begin start = cyc_idle; kind = CY_RDAT; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         op_q        <= OP_READ;
         row_q       <= '0;
         col_q       <= '0;
         half_q      <= 1'b0;
         len_q       <= '0;
         idx         <= '0;
         guard       <= '0;
         err_prot    <= 1'b0;
         err_fail    <= 1'b0;
         status_byte <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid) begin
               op_q     <= nseq_op_e'(req_op);
               row_q    <= req_row;
               col_q    <= req_col;
               half_q   <= req_half;
               len_q    <= req_len;
               err_fail <= 1'b0;
               if ((req_op == OP_PROG || req_op == OP_ERASE) && !wprot_n) begin
                  err_prot <= 1'b1;
                  st       <= ST_DONE;
               end else begin
                  err_prot <= 1'b0;
                  st       <= ST_CMD1;
               end
            end
            ST_CMD1: if (cyc_done) begin
               case (op_q)
                  OP_STAT:  begin st <= ST_RDAT; idx <= '0; len_q <= LEN_W'(1); end
                  OP_ERASE: begin st <= ST_ADDR; idx <= LEN_W'(1); end
                  default:  begin st <= ST_ADDR; idx <= '0; end
               endcase
            end
            ST_ADDR: if (cyc_done) begin
               if (idx == LEN_W'(2)) begin
                  idx <= '0;
                  case (op_q)
                     OP_READ: begin st <= ST_WAIT; guard <= GW'(GUARD); end
                     OP_PROG: st <= (len_q == '0) ? ST_CMD2 : ST_WDAT;
                     default: st <= ST_CMD2;
                  endcase
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_WDAT: if (cyc_done) begin
               if (idx == len_q - 1'b1) st <= ST_CMD2;
               idx <= idx + 1'b1;
            end
            ST_CMD2: if (cyc_done) begin
               st    <= ST_WAIT;
               guard <= GW'(GUARD);
            end
            ST_WAIT: begin
               if (guard != '0) guard <= guard - 1'b1;
               else if (ready) begin
                  idx <= '0;
                  if (op_q != OP_READ) st <= ST_SCMD;
                  else st <= (len_q == '0) ? ST_DONE : ST_RDAT;
               end
            end
            ST_SCMD: if (cyc_done) begin
               st    <= ST_RDAT;
               idx   <= '0;
               len_q <= LEN_W'(1);
            end
            ST_RDAT: if (cyc_done) begin
               if (idx == len_q - 1'b1) begin
                  st <= ST_DONE;
                  if (op_q != OP_READ) begin
                     status_byte <= rbyte;
                     err_fail    <= (op_q == OP_PROG || op_q == OP_ERASE) && rbyte[0];
                  end
               end
               idx <= idx + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign done      = (st == ST_DONE);
   assign wr_ready  = (st == ST_WDAT) && cyc_idle;
   assign rd_valid  = (st == ST_RDAT) && cyc_done && (op_q == OP_READ);
   assign sel_n     = (st == ST_IDLE) || (st == ST_DONE);
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nseq_pkg::*;
#(
   parameter int PULSE_CYC  = 2,
   parameter int ROW_W      = 14,
   parameter int PAGE_BYTES = 528,
   parameter int GUARD      = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   output logic                              req_ready,
   input  logic [1:0]                        req_op,
   input  logic [ROW_W-1:0]                  req_row,
   input  logic [7:0]                        req_col,
   input  logic                              req_half,
   input  logic [$clog2(PAGE_BYTES+1)-1:0]   req_len,
   input  logic [7:0]                        wr_byte,
   input  logic                              wr_valid,
   output logic                              wr_ready,
   output logic [7:0]                        rd_byte,
   output logic                              rd_valid,
   output logic                              done,
   output logic                              err_prot,
   output logic                              err_fail,
   output logic [7:0]                        status_byte,
   output logic                              flash_sel_n,
   output logic                              flash_cmd_en,
   output logic                              flash_addr_en,
   output logic                              flash_wr_n,
   output logic                              flash_rd_n,
   output logic [7:0]                        flash_bus_out,
   output logic                              flash_bus_oe,
   input  logic [7:0]                        flash_bus_in,
   input  logic                              flash_wprot_n,
   input  logic                              flash_ready
);
   localparam int LEN_W = $clog2(PAGE_BYTES + 1);

   generate
      if (PULSE_CYC < 2) begin : g_bad_pulse
         $error("PULSE_CYC must be at least 2");
      end
      if (ROW_W <= 8 || ROW_W > 16) begin : g_bad_row
         $error("ROW_W must fit two address bytes");
      end
      if (GUARD < 2) begin : g_bad_guard
         $error("GUARD must cover the ready line latency");
      end
   endgenerate

   logic             start, cyc_idle, cyc_done;
   nseq_cyc_e        kind;
   logic [BUS_W-1:0] wbyte, rbyte;

   nseq_ctrl #(.ROW_W(ROW_W), .LEN_W(LEN_W), .GUARD(GUARD)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_row(req_row), .req_col(req_col),
      .req_half(req_half), .req_len(req_len),
      .wr_valid(wr_valid), .wr_byte(wr_byte),
      .wprot_n(flash_wprot_n), .ready(flash_ready),
      .cyc_idle(cyc_idle), .cyc_done(cyc_done), .rbyte(rbyte),
      .start(start), .kind(kind), .wbyte(wbyte), .wr_ready(wr_ready),
      .req_ready(req_ready), .done(done), .err_prot(err_prot), .err_fail(err_fail),
      .status_byte(status_byte), .rd_valid(rd_valid), .sel_n(flash_sel_n)
   );

   nseq_strobe #(.PULSE_CYC(PULSE_CYC)) u_strobe (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .wbyte(wbyte),
      .bus_in(flash_bus_in), .idle(cyc_idle), .cyc_done(cyc_done),
      .cmd_en(flash_cmd_en), .addr_en(flash_addr_en),
      .wr_n(flash_wr_n), .rd_n(flash_rd_n),
      .bus_out(flash_bus_out), .bus_oe(flash_bus_oe), .rbyte(rbyte)
   );

   assign rd_byte = rbyte;
endmodule

// File: rtl/nseq_chk.sv
module nseq_chk #(
   parameter int PULSE_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic done,
   input logic err_prot,
   input logic flash_sel_n,
   input logic flash_cmd_en,
   input logic flash_addr_en,
   input logic flash_wr_n,
   input logic flash_rd_n,
   input logic flash_bus_oe,
   input logic flash_ready
);
   localparam int WW = $clog2(PULSE_CYC + 1) + 1;

   logic          strobe_low;
   logic [WW-1:0] lo_cnt, hi_cnt;

   assign strobe_low = !flash_wr_n || !flash_rd_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= WW'(PULSE_CYC);
      end else if (strobe_low) begin
         lo_cnt <= lo_cnt + 1'b1;
         hi_cnt <= '0;
      end else begin
         lo_cnt <= '0;
         if (hi_cnt < WW'(PULSE_CYC)) hi_cnt <= hi_cnt + 1'b1;
      end
   end

   AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> flash_sel_n && flash_wr_n && flash_rd_n && !flash_cmd_en && !flash_addr_en); // R1
   AST_LOW_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_low |-> lo_cnt < WW'(PULSE_CYC)); // R2
   AST_LOW_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_low && lo_cnt != '0) |-> lo_cnt == WW'(PULSE_CYC)); // R2
   AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_low && lo_cnt == '0) |-> hi_cnt >= WW'(PULSE_CYC)); // R2
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!flash_wr_n && !flash_rd_n)); // R2
   AST_LATCH_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      !(flash_cmd_en && flash_addr_en)); // R3
   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_rd_n |-> !flash_bus_oe); // R4
   AST_PROT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_prot) |-> flash_sel_n); // R8
   AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_low && lo_cnt == '0) |-> flash_ready); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && req_ready); // R11
endmodule

bind nand_cycle_seq nseq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .err_prot(err_prot),
   .flash_sel_n(flash_sel_n), .flash_cmd_en(flash_cmd_en), .flash_addr_en(flash_addr_en),
   .flash_wr_n(flash_wr_n), .flash_rd_n(flash_rd_n), .flash_bus_oe(flash_bus_oe),
   .flash_ready(flash_ready)
);

// File: tb/nand_cycle_seq_tb.sv
module nand_cycle_seq_tb;
   localparam int P        = 3;
   localparam int PG       = 528;
   localparam int FAIL_ROW = 99;

   logic clk = 0, rst_n = 0;
   always #5 clk = ~clk;

   logic       req_valid = 0, req_half = 0, wr_valid = 0, wprot_n = 1;
   logic [1:0] req_op = 0;
   logic [13:0] req_row = 0;
   logic [7:0] req_col = 0, wr_byte = 0, bus_in = 8'hFF;
   logic [9:0] req_len = 0;
   logic req_ready, wr_ready, rd_valid, done, err_prot, err_fail;
   logic [7:0] rd_byte, status_byte, bus_out;
   logic sel_n, cmd_en, addr_en, wr_n, rd_n, bus_oe;
   logic f_ready;

   nand_cycle_seq #(.PULSE_CYC(P)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_row(req_row), .req_col(req_col), .req_half(req_half),
      .req_len(req_len), .wr_byte(wr_byte), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_byte(rd_byte), .rd_valid(rd_valid), .done(done), .err_prot(err_prot),
      .err_fail(err_fail), .status_byte(status_byte), .flash_sel_n(sel_n),
      .flash_cmd_en(cmd_en), .flash_addr_en(addr_en), .flash_wr_n(wr_n),
      .flash_rd_n(rd_n), .flash_bus_out(bus_out), .flash_bus_oe(bus_oe),
      .flash_bus_in(bus_in), .flash_wprot_n(wprot_n), .flash_ready(f_ready)
   );

   int n_chk = 0, n_err = 0;
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wrap_up();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // behavioural flash device
   logic [7:0] mem [int];
   logic [7:0] pbuf [PG];
   int obs[$];
   int busy_cnt = 0, mode = 0, n_addr = 0, a_col = 0, a_row = 0, base = 0, ptr = 0;
   bit stat_mode = 0, prev_we = 1, prev_re = 1;
   logic [7:0] fstat = 8'hC0;
   assign f_ready = (busy_cnt == 0);

   function automatic logic [7:0] rdm(input int k);
      return mem.exists(k) ? mem[k] : 8'hFF;
   endfunction

   always @(posedge clk) begin
      if (busy_cnt > 0) busy_cnt--;
      if (!sel_n && wr_n && !prev_we) begin
         if (cmd_en) begin
            obs.push_back(int'(bus_out));
            n_addr = 0; stat_mode = 0;
            case (bus_out)
               8'h00: begin mode = 0; base = 0; end
               8'h01: begin mode = 0; base = 256; end
               8'h80: begin mode = 1; for (int i = 0; i < PG; i++) pbuf[i] = 8'hFF; end
               8'h10: begin
                  for (int i = 0; i < PG; i++)
                     if (pbuf[i] != 8'hFF) mem[a_row*PG+i] = rdm(a_row*PG+i) & pbuf[i];
                  busy_cnt = 20;
                  fstat = (a_row == FAIL_ROW) ? 8'hC1 : 8'hC0;
               end
               8'h60: mode = 2;
               8'hD0: begin
                  for (int r = (a_row/16)*16; r < (a_row/16)*16+16; r++)
                     for (int c = 0; c < PG; c++) if (mem.exists(r*PG+c)) mem.delete(r*PG+c);
                  busy_cnt = 30; fstat = 8'hC0;
               end
               8'h70: stat_mode = 1;
               default: ;
            endcase
         end else if (addr_en) begin
            obs.push_back(256 + int'(bus_out));
            if (mode == 2) begin
               if (n_addr == 0) a_row = int'(bus_out); else a_row += int'(bus_out) * 256;
            end else begin
               if (n_addr == 0) a_col = int'(bus_out);
               else if (n_addr == 1) a_row = int'(bus_out);
               else begin
                  a_row += int'(bus_out) * 256;
                  if (mode == 0) begin ptr = base + a_col; busy_cnt = 15; end
                  else ptr = a_col;
               end
            end
            n_addr++;
         end else begin
            obs.push_back(512 + int'(bus_out));
            if (ptr < PG) pbuf[ptr] = bus_out;
            ptr++;
         end
      end
      if (!sel_n && !rd_n && prev_re) begin
         bus_in <= stat_mode ? fstat : rdm(a_row*PG + ptr);
         if (!stat_mode) ptr++;
      end
      prev_we = wr_n;
      prev_re = rd_n;
   end

   // write stream feeder
   logic [7:0] wq[$];
   bit took = 0;
   always @(posedge clk) took <= wr_valid && wr_ready;
   always @(negedge clk) begin
      if (took && wq.size() > 0) void'(wq.pop_front());
      wr_valid = (wq.size() > 0);
      wr_byte  = (wq.size() > 0) ? wq[0] : 8'h00;
   end

   // every-cycle monitors
   logic [7:0] got_rd[$];
   int lo_w = 0, hi_w = 100, busy_viol = 0, qual_viol = 0;
   always @(negedge clk) if (rst_n) begin
      if (rd_valid) got_rd.push_back(rd_byte);
      if (!f_ready && (!wr_n || !rd_n) && lo_w == 0) busy_viol++;
      if (cmd_en && addr_en) qual_viol++;
      if (!wr_n || !rd_n) begin
         if (lo_w == 0) chk(hi_w >= P, "R2 high width", hi_w, P);
         lo_w++; hi_w = 0;
      end else begin
         if (lo_w > 0) chk(lo_w == P, "R2 low width", lo_w, P);
         lo_w = 0; hi_w++;
      end
   end

   int exp_bus[$];
   logic [7:0] exp_rd[$];
   int lat;

   task automatic run_op(input int op, input int row, input int col, input bit half,
                         input int len, input string tag);
      obs.delete(); got_rd.delete();
      @(negedge clk);
      chk(req_ready, {tag, " R11 ready before"}, req_ready, 1);
      req_valid = 1; req_op = 2'(op); req_row = 14'(row); req_col = 8'(col);
      req_half = half; req_len = 10'(len);
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      lat = 1;
      if (!done) chk(!req_ready, {tag, " R11 busy after accept"}, req_ready, 0);
      while (!done) begin @(negedge clk); lat++; end
      @(negedge clk);
      chk(!done && req_ready, {tag, " R11 done one cycle"}, done, 0);
      chk(obs.size() == exp_bus.size(), {tag, " bus byte count"}, obs.size(), exp_bus.size());
      for (int i = 0; i < exp_bus.size() && i < obs.size(); i++)
         chk(obs[i] == exp_bus[i], {tag, " bus byte"}, obs[i], exp_bus[i]);
      chk(got_rd.size() == exp_rd.size(), {tag, " read count"}, got_rd.size(), exp_rd.size());
      for (int i = 0; i < exp_rd.size() && i < got_rd.size(); i++)
         chk(got_rd[i] == exp_rd[i], {tag, " read byte"}, got_rd[i], exp_rd[i]);
   endtask

   // kind tags in expected queue: 0 command, 256 address, 512 data
   task automatic exp_addr3(input int row, input int col);
      exp_bus.push_back(256 + col);
      exp_bus.push_back(256 + (row % 256));
      exp_bus.push_back(256 + (row / 256));
   endtask

   logic [7:0] d_small[6] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
   bit seen_prot_flag, seen_fail_flag;

   always @(negedge clk) if (done) begin
      seen_prot_flag = err_prot;
      seen_fail_flag = err_fail;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: run did not finish");
      wrap_up();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset levels
      chk(sel_n && wr_n && rd_n && !cmd_en && !addr_en && req_ready, "R1 idle levels",
          {sel_n, wr_n, rd_n, cmd_en, addr_en, req_ready}, 6'b111001);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(sel_n && wr_n && rd_n && !cmd_en && !addr_en, "R1 after reset", sel_n, 1);

      // R7: status read
      exp_bus = '{8'h70}; exp_rd.delete();
      run_op(3, 0, 0, 0, 0, "R7 status");
      chk(status_byte == 8'hC0, "R7 status byte", status_byte, 8'hC0);
      chk(!seen_fail_flag && !seen_prot_flag, "R10 no error on status", seen_fail_flag, 0);

      // R5: program six bytes at row 5 column 3
      foreach (d_small[i]) wq.push_back(d_small[i]);
      exp_bus = '{8'h80}; exp_addr3(5, 3);
      foreach (d_small[i]) exp_bus.push_back(512 + d_small[i]);
      exp_bus.push_back(8'h10); exp_bus.push_back(8'h70);
      exp_rd.delete();
      run_op(1, 5, 3, 0, 6, "R5 program");
      chk(!seen_fail_flag, "R10 program pass", seen_fail_flag, 0);

      // R4: read lower half row 5 from column 0
      exp_bus = '{8'h00}; exp_addr3(5, 0);
      exp_rd = '{8'hFF, 8'hFF, 8'hFF, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hFF};
      run_op(0, 5, 0, 0, 10, "R4 read low");

      // R5 long program spanning into upper half, row with upper bits set
      for (int i = 0; i < 260; i++) wq.push_back(8'((i * 7 + 3) & 8'hFF));
      exp_bus = '{8'h80}; exp_addr3(14'h2A7, 0);
      for (int i = 0; i < 260; i++) exp_bus.push_back(512 + ((i * 7 + 3) & 255));
      exp_bus.push_back(8'h10); exp_bus.push_back(8'h70);
      exp_rd.delete();
      run_op(1, 14'h2A7, 0, 0, 260, "R5 long program");

      // R4: upper-half pointer read
      exp_bus = '{8'h01}; exp_addr3(14'h2A7, 1);
      exp_rd.delete();
      for (int i = 257; i < 260; i++) exp_rd.push_back(8'((i * 7 + 3) & 8'hFF));
      exp_rd.push_back(8'hFF);
      run_op(0, 14'h2A7, 1, 1, 4, "R4 read high");

      // R10: failing program
      wq.push_back(8'h00);
      exp_bus = '{8'h80}; exp_addr3(FAIL_ROW, 0);
      exp_bus.push_back(512); exp_bus.push_back(8'h10); exp_bus.push_back(8'h70);
      exp_rd.delete();
      run_op(1, FAIL_ROW, 0, 0, 1, "R10 failing program");
      chk(seen_fail_flag, "R10 fail flag", seen_fail_flag, 1);
      chk(status_byte == 8'hC1, "R10 status byte", status_byte, 8'hC1);

      // R8: write protect refuses program and erase
      wprot_n = 0;
      exp_bus.delete(); exp_rd.delete();
      run_op(1, 5, 0, 0, 4, "R8 protected program");
      chk(lat == 1, "R8 done latency", lat, 1);
      chk(seen_prot_flag, "R8 prot flag", seen_prot_flag, 1);
      run_op(2, 5, 0, 0, 0, "R8 protected erase");
      chk(seen_prot_flag && lat == 1, "R8 erase refused", lat, 1);
      wprot_n = 1;

      // R6: erase the block holding row 5 (row 7 selects block 0)
      exp_bus = '{8'h60, 256 + 7, 256, 8'hD0, 8'h70}; exp_rd.delete();
      run_op(2, 7, 0, 0, 0, "R6 erase");
      chk(!seen_prot_flag && !seen_fail_flag, "R6 erase flags", seen_fail_flag, 0);
      exp_bus = '{8'h00}; exp_addr3(5, 3);
      exp_rd = '{8'hFF, 8'hFF, 8'hFF};
      run_op(0, 5, 3, 0, 3, "R6 erased read");

      chk(busy_viol == 0, "R9 pulse while busy", busy_viol, 0);
      chk(qual_viol == 0, "R3 both strobes", qual_viol, 0);
      wrap_up();
   end
endmodule